// File: doc/BRIEF.md
# Character-Granular CRTC Timing Generator

This block produces the raster timing for a video output: a horizontal sync, a vertical sync, a display-enable strobe, and the position of the current pixel. The pixel clock is the block's clock, and the block counts one pixel per cycle. Horizontal timing is programmed in character cells of eight pixels. Vertical timing is programmed in scan lines. Every count is written as its value minus one.

Software programs the block through a small word-wide register bus. Four timing registers hold the totals, the display extents, the sync starts, the sync widths and a per-axis polarity bit. A control word holds the run enable, a lock that freezes the timing registers, and a colour-depth code that is forwarded to the pixel pipeline. A pitch word is held for the fetch logic, and a read-only word returns the current scan line. Timing edits made while the raster runs are staged in shadow copies and are adopted at the next frame boundary.

Top module: `crtc_char_timing`

## Requirements
- R1: After reset, de, hsync and vsync are low, pix_x, line_y and pix_depth are zero, and every readable register returns zero.
- R2: Register 0 holds (characters per line − 1) in bits 8:0 and (displayed characters − 1) in bits 24:16. While enabled, pix_x = 8·character + pixel-in-character, advances by one each clock, and returns to 0 after 8·(total+1) pixels.
- R3: de is high exactly when the current character is ≤ the displayed-characters field and the current line is ≤ the displayed-lines field.
- R4: Register 1 holds (sync start character − 1) in bits 8:0 and the sync width in characters in bits 20:16. Horizontal sync is active for characters c with start ≤ c < start + width.
- R5: Register 2 holds (lines per frame − 1) in bits 10:0 and (displayed lines − 1) in bits 26:16. Register 3 holds (sync start line − 1) in bits 10:0 and the sync width in lines in bits 20:16. line_y advances when pix_x wraps, returns to 0 after total+1 lines, and vertical sync is active for lines start ≤ line < start + width.
- R6: Bit 21 of register 1 and of register 3, when set, inverts that axis's sync output, so that the idle level becomes 1.
- R7: Bit 25 of control register 5 enables the generator. While the bit is clear, de is low, both syncs sit at their idle level, and from the following cycle pix_x and line_y are held at 0.
- R8: While bit 22 of register 5 is set, writes to registers 0 to 3 are ignored and read back unchanged. Register 5 stays writable, and clearing the bit unlocks the timing registers.
- R9: A timing write made while the generator runs shows at once on readback, but the outputs keep the old timing until the last pixel of the current frame. The new timing starts with the next frame.
- R10: Bits 10:8 of register 5 drive pix_depth (1 = 1 bpp, 2 = 8 bpp, 3 = 15 bpp, 4 = 16 bpp, 5 = 24 bpp, 6 = 32 bpp). The value changes only after a write to register 5.
- R11: Register 4 keeps the line pitch, in units of 8 pixels, in bits 31:22. Its other bits read back as zero.
- R12: Reading register 6 returns the current line_y in bits 10:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Display enable |
| pix_x | output | 12 | Pixel position within the line |
| line_y | output | 11 | Current scan line |
| pix_depth | output | 3 | Colour-depth code |

## Verification
A register write is taken at the clock edge where reg_we is high. Its readback is valid in the half-cycle that follows that edge. A write that sets the enable puts pixel 0 on the outputs right after the same edge, and each later pixel follows one clock after the one before. A polarity change made while the generator is stopped reaches the sync pins one edge later, because the idle block copies its staged timing on every edge. The bench stamps every expected output sample with the absolute cycle in which it is due, and a monitor five nanoseconds after each rising edge compares only the samples whose stamp matches. A mid-frame timing write is therefore checked to take effect exactly at the frame boundary and neither earlier nor later.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int REG_DW = 32;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] ADR_HTIM  = 3'd0;
  localparam logic [REG_AW-1:0] ADR_HSYN  = 3'd1;
  localparam logic [REG_AW-1:0] ADR_VTIM  = 3'd2;
  localparam logic [REG_AW-1:0] ADR_VSYN  = 3'd3;
  localparam logic [REG_AW-1:0] ADR_PITCH = 3'd4;
  localparam logic [REG_AW-1:0] ADR_CTRL  = 3'd5;
  localparam logic [REG_AW-1:0] ADR_LINE  = 3'd6;

  localparam int HI_LSB    = 16;
  localparam int POL_BIT   = 21;
  localparam int LOCK_BIT  = 22;
  localparam int EN_BIT    = 25;
  localparam int DEPTH_LSB = 8;
  localparam int DEPTH_W   = 3;
  localparam int PITCH_LSB = 22;
endpackage

// File: rtl/crtc_axis.sv
module crtc_axis #(
  parameter int CW  = 9,
  parameter int SWW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           step,
  input  logic [CW-1:0]  tot,
  input  logic [CW-1:0]  disp,
  input  logic [CW-1:0]  sst,
  input  logic [SWW-1:0] swid,
  output logic [CW-1:0]  cnt,
  output logic           last,
  output logic           vis,
  output logic           sync_on
);
  localparam int EW = CW + 2;

  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic [EW-1:0] c_ext, s_beg, s_end;

  assign last = (cnt == tot);
  assign vis  = (cnt <= disp);

  always_comb begin
    cnt_en = !run || step;
    cnt_d  = (!run || last) ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  always_comb begin
    c_ext   = {2'b00, cnt};
    s_beg   = {2'b00, sst} + 1'b1;
    s_end   = s_beg + {{(EW-SWW){1'b0}}, swid};
    sync_on = run && (c_ext >= s_beg) && (c_ext < s_end);
  end
endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_pkg::*;
#(
  parameter int HW  = 9,
  parameter int VW  = 11,
  parameter int SWW = 5,
  parameter int PW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  input  logic              load_act,
  input  logic [VW-1:0]     line_cnt,
  output logic [REG_DW-1:0] rdata,
  output logic              en,
  output logic [DEPTH_W-1:0] depth,
  output logic [HW-1:0]     a_htot, a_hdisp, a_hss,
  output logic [SWW-1:0]    a_hsw,
  output logic              a_hneg,
  output logic [VW-1:0]     a_vtot, a_vdisp, a_vss,
  output logic [SWW-1:0]    a_vsw,
  output logic              a_vneg
);
  logic [HW-1:0]  s_htot, s_hdisp, s_hss;
  logic [SWW-1:0] s_hsw, s_vsw;
  logic           s_hneg, s_vneg, lock;
  logic [VW-1:0]  s_vtot, s_vdisp, s_vss;
  logic [PW-1:0]  pitch;
  logic wr_htim, wr_hsyn, wr_vtim, wr_vsyn, wr_pitch, wr_ctrl, tim_ok;

  always_comb begin
    tim_ok   = we && !lock;
    wr_htim  = tim_ok && (addr == ADR_HTIM);
    wr_hsyn  = tim_ok && (addr == ADR_HSYN);
    wr_vtim  = tim_ok && (addr == ADR_VTIM);
    wr_vsyn  = tim_ok && (addr == ADR_VSYN);
    wr_pitch = we && (addr == ADR_PITCH);
    wr_ctrl  = we && (addr == ADR_CTRL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_htot <= '0; s_hdisp <= '0; s_hss <= '0; s_hsw <= '0; s_hneg <= 1'b0;
      s_vtot <= '0; s_vdisp <= '0; s_vss <= '0; s_vsw <= '0; s_vneg <= 1'b0;
      pitch <= '0; en <= 1'b0; lock <= 1'b0; depth <= '0;
    end else begin
      if (wr_htim) begin
        s_htot  <= wdata[HW-1:0];
        s_hdisp <= wdata[HI_LSB +: HW];
      end
      if (wr_hsyn) begin
        s_hss  <= wdata[HW-1:0];
        s_hsw  <= wdata[HI_LSB +: SWW];
        s_hneg <= wdata[POL_BIT];
      end
      if (wr_vtim) begin
        s_vtot  <= wdata[VW-1:0];
        s_vdisp <= wdata[HI_LSB +: VW];
      end
      if (wr_vsyn) begin
        s_vss  <= wdata[VW-1:0];
        s_vsw  <= wdata[HI_LSB +: SWW];
        s_vneg <= wdata[POL_BIT];
      end
      if (wr_pitch) pitch <= wdata[PITCH_LSB +: PW];
      if (wr_ctrl) begin
        en    <= wdata[EN_BIT];
        lock  <= wdata[LOCK_BIT];
        depth <= wdata[DEPTH_LSB +: DEPTH_W];
      end
    end
  end

  // working copies, refreshed only at frame boundaries or while idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_htot <= '0; a_hdisp <= '0; a_hss <= '0; a_hsw <= '0; a_hneg <= 1'b0;
      a_vtot <= '0; a_vdisp <= '0; a_vss <= '0; a_vsw <= '0; a_vneg <= 1'b0;
    end else if (load_act) begin
      a_htot <= s_htot; a_hdisp <= s_hdisp; a_hss <= s_hss; a_hsw <= s_hsw; a_hneg <= s_hneg;
      a_vtot <= s_vtot; a_vdisp <= s_vdisp; a_vss <= s_vss; a_vsw <= s_vsw; a_vneg <= s_vneg;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      ADR_HTIM: begin
        rdata[HW-1:0]        = s_htot;
        rdata[HI_LSB +: HW]  = s_hdisp;
      end
      ADR_HSYN: begin
        rdata[HW-1:0]        = s_hss;
        rdata[HI_LSB +: SWW] = s_hsw;
        rdata[POL_BIT]       = s_hneg;
      end
      ADR_VTIM: begin
        rdata[VW-1:0]        = s_vtot;
        rdata[HI_LSB +: VW]  = s_vdisp;
      end
      ADR_VSYN: begin
        rdata[VW-1:0]        = s_vss;
        rdata[HI_LSB +: SWW] = s_vsw;
        rdata[POL_BIT]       = s_vneg;
      end
      ADR_PITCH: rdata[PITCH_LSB +: PW] = pitch;
      ADR_CTRL: begin
        rdata[EN_BIT]                = en;
        rdata[LOCK_BIT]              = lock;
        rdata[DEPTH_LSB +: DEPTH_W]  = depth;
      end
      ADR_LINE: rdata[VW-1:0] = line_cnt;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/crtc_char_timing.sv
module crtc_char_timing
  import crtc_pkg::*;
#(
  parameter int HW      = 9,
  parameter int VW      = 11,
  parameter int SWW     = 5,
  parameter int PW      = 10,
  parameter int CHAR_PX = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [REG_DW-1:0]  reg_wdata,
  output logic [REG_DW-1:0]  reg_rdata,
  output logic               hsync,
  output logic               vsync,
  output logic               de,
  output logic [HW+$clog2(CHAR_PX)-1:0] pix_x,
  output logic [VW-1:0]      line_y,
  output logic [DEPTH_W-1:0] pix_depth
);
  localparam int PXB = $clog2(CHAR_PX);

  logic [1:0]     rst_pipe;
  logic           rst_int;
  logic           run, load_act, frame_end;
  logic [PXB-1:0] px, px_d;
  logic           px_last, v_step;
  logic [HW-1:0]  a_htot, a_hdisp, a_hss, hcnt;
  logic [VW-1:0]  a_vtot, a_vdisp, a_vss, vcnt;
  logic [SWW-1:0] a_hsw, a_vsw;
  logic           a_hneg, a_vneg;
  logic           h_last, h_vis, h_on, v_last, v_vis, v_on;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int = rst_pipe[1];

  crtc_regs #(.HW(HW), .VW(VW), .SWW(SWW), .PW(PW)) u_regs (
    .clk(clk), .rst_n(rst_int), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .load_act(load_act), .line_cnt(vcnt), .rdata(reg_rdata),
    .en(run), .depth(pix_depth),
    .a_htot(a_htot), .a_hdisp(a_hdisp), .a_hss(a_hss), .a_hsw(a_hsw), .a_hneg(a_hneg),
    .a_vtot(a_vtot), .a_vdisp(a_vdisp), .a_vss(a_vss), .a_vsw(a_vsw), .a_vneg(a_vneg)
  );

  always_comb begin
    px_last   = (px == PXB'(CHAR_PX - 1));
    px_d      = (!run || px_last) ? '0 : px + 1'b1;
    v_step    = px_last && h_last;
    frame_end = run && v_step && v_last;
    load_act  = !run || frame_end;
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) px <= '0;
    else          px <= px_d;
  end

  crtc_axis #(.CW(HW), .SWW(SWW)) u_h (
    .clk(clk), .rst_n(rst_int), .run(run), .step(px_last),
    .tot(a_htot), .disp(a_hdisp), .sst(a_hss), .swid(a_hsw),
    .cnt(hcnt), .last(h_last), .vis(h_vis), .sync_on(h_on)
  );

  crtc_axis #(.CW(VW), .SWW(SWW)) u_v (
    .clk(clk), .rst_n(rst_int), .run(run), .step(v_step),
    .tot(a_vtot), .disp(a_vdisp), .sst(a_vss), .swid(a_vsw),
    .cnt(vcnt), .last(v_last), .vis(v_vis), .sync_on(v_on)
  );

  assign pix_x  = {hcnt, px};
  assign line_y = vcnt;
  assign de     = run && h_vis && v_vis;
  assign hsync  = h_on ^ a_hneg;
  assign vsync  = v_on ^ a_vneg;
endmodule

// File: rtl/crtc_chk.sv
module crtc_chk #(
  parameter int XW = 12,
  parameter int YW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          de,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] line_y,
  input logic [2:0]    pix_depth,
  input logic          reg_we,
  input logic [2:0]    reg_addr
);
  // R2: pixel position moves by one per clock or wraps to zero
  a_r2_x_advance: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (!run || pix_x == '0 || pix_x == $past(pix_x) + 1'b1));

  // R5: the line only changes when the pixel position wraps
  a_r5_line_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pix_x != '0) |-> $stable(line_y));

  // R7: no display enable while stopped
  a_r7_idle_de: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !de);

  // R7: counters cleared one cycle after being stopped
  a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pix_x == '0 && line_y == '0));

  // R10: depth code changes only through a control write
  a_r10_depth_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == 3'd5) |=> $stable(pix_depth));
endmodule

bind crtc_char_timing crtc_chk #(.XW($bits(pix_x)), .YW($bits(line_y))) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .de(de), .pix_x(pix_x), .line_y(line_y),
  .pix_depth(pix_depth), .reg_we(reg_we), .reg_addr(reg_addr)
);

// File: tb/sim_crtc_char_timing.sv
module sim_crtc_char_timing;
  logic        clk, rst_n, reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        hsync, vsync, de;
  logic [11:0] pix_x;
  logic [10:0] line_y;
  logic [2:0]  pix_depth;

  crtc_char_timing u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hsync(hsync), .vsync(vsync),
    .de(de), .pix_x(pix_x), .line_y(line_y), .pix_depth(pix_depth)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    int cyc; int x; int y; logic de; logic hs; logic vs;
  } item_t;
  item_t q[$];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compare every sample due in this cycle
  always @(posedge clk) begin
    #5;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      item_t it;
      it = q.pop_front();
      chk(it.cyc == cyc, "R2 sample missed", it.cyc, cyc);
      chk(pix_x == it.x[11:0], "R2 pix_x", pix_x, it.x);
      chk(line_y == it.y[10:0], "R5 line_y", line_y, it.y);
      chk(de == it.de, "R3 de", de, it.de);
      chk(hsync == it.hs, "R4/R6 hsync", hsync, it.hs);
      chk(vsync == it.vs, "R5/R6 vsync", vsync, it.vs);
    end
  end

  // driver: expected raster for one configuration, n samples from cycle c0
  task automatic push_raster(input int c0, input int n,
                             input int ht, input int hd, input int hs, input int hw, input bit hn,
                             input int vt, input int vd, input int vs, input int vw, input bit vn);
    int ppl, fr;
    ppl = 8 * (ht + 1);
    fr  = ppl * (vt + 1);
    for (int k = 0; k < n; k++) begin
      item_t it;
      int p, x, ln, ch;
      p  = k % fr;
      x  = p % ppl;
      ln = p / ppl;
      ch = x / 8;
      it.cyc = c0 + k;
      it.x   = x;
      it.y   = ln;
      it.de  = (ch <= hd) && (ln <= vd);
      it.hs  = ((ch >= hs + 1) && (ch < hs + 1 + hw)) ^ hn;
      it.vs  = ((ln >= vs + 1) && (ln < vs + 1 + vw)) ^ vn;
      q.push_back(it);
    end
  endtask

  // called at a falling edge; write taken at the next rising edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, reg_rdata, e);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  localparam logic [31:0] HTIM_A = (32'd1 << 16) | 32'd3;
  localparam logic [31:0] HTIM_B = (32'd3 << 16) | 32'd5;
  localparam logic [31:0] HSYN_A = (32'd1 << 16) | 32'd2;
  localparam logic [31:0] VTIM_A = (32'd2 << 16) | 32'd4;
  localparam logic [31:0] VSYN_A = (32'd1 << 16) | 32'd2;
  localparam logic [31:0] NEG    = 32'd1 << 21;
  localparam logic [31:0] EN     = 32'd1 << 25;
  localparam logic [31:0] LOCK   = 32'd1 << 22;

  initial begin
    int c0, c1;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(de == 1'b0, "R1 de", de, 0);
    chk(hsync == 1'b0 && vsync == 1'b0, "R1 syncs", {hsync, vsync}, 0);
    chk(pix_x == 0 && line_y == 0, "R1 position", pix_x, 0);
    chk(pix_depth == 0, "R1 pix_depth", pix_depth, 0);
    rd_chk(3'd0, 32'h0, "R1 htim");
    rd_chk(3'd5, 32'h0, "R1 ctrl");
    @(negedge clk);

    // program timing while stopped
    wr(3'd0, HTIM_A);
    wr(3'd1, HSYN_A);
    wr(3'd2, VTIM_A);
    wr(3'd3, VSYN_A);
    wr(3'd4, 32'h0A80_00FF);
    rd_chk(3'd4, 32'h0A80_0000, "R11 pitch");
    rd_chk(3'd0, HTIM_A, "R2 htim readback");
    rd_chk(3'd3, VSYN_A, "R5 vsyn readback");
    @(negedge clk);

    // R10: depth code
    wr(3'd5, 32'd2 << 8);
    chk(pix_depth == 3'd2, "R10 depth 8bpp", pix_depth, 2);

    // R8: lock ignores timing writes
    wr(3'd5, LOCK | (32'd2 << 8));
    wr(3'd0, 32'h0011_0022);
    wr(3'd1, 32'h0000_0007);
    rd_chk(3'd0, HTIM_A, "R8 locked htim");
    rd_chk(3'd1, HSYN_A, "R8 locked hsyn");
    @(negedge clk);
    wr(3'd5, 32'd4 << 8);
    wr(3'd2, VTIM_A);
    rd_chk(3'd5, 32'd4 << 8, "R8 unlock ctrl");
    rd_chk(3'd2, VTIM_A, "R8 write after unlock");
    chk(pix_depth == 3'd4, "R10 depth 16bpp", pix_depth, 4);
    @(negedge clk);

    // enable: frame A (4x8 px, 5 lines) then frame B (6x8 px)
    c0 = cyc;
    push_raster(c0 + 1, 160, 3, 1, 2, 1, 0, 4, 2, 2, 1, 0);
    push_raster(c0 + 161, 240, 5, 3, 2, 1, 0, 4, 2, 2, 1, 0);
    wr(3'd5, EN | (32'd4 << 8));
    wait_cyc(c0 + 60);
    // R12: line readback, sample index 59 -> line 1
    rd_chk(3'd6, 32'd1, "R12 line readback");
    @(negedge clk);
    // R9: change width mid-frame; takes effect at next frame
    wr(3'd0, HTIM_B);
    rd_chk(3'd0, HTIM_B, "R9 shadow readback");
    wait_cyc(c0 + 403);

    // R7: stop
    wr(3'd5, 32'd4 << 8);
    chk(de == 1'b0, "R7 de idle", de, 0);
    chk(hsync == 1'b0 && vsync == 1'b0, "R7 syncs idle", {hsync, vsync}, 0);
    @(negedge clk);
    chk(pix_x == 0 && line_y == 0, "R7 counters held", pix_x, 0);

    // R6: negative polarity idles high
    wr(3'd1, HSYN_A | NEG);
    wr(3'd3, VSYN_A | NEG);
    @(negedge clk);
    chk(hsync == 1'b1, "R6 hsync idle high", hsync, 1);
    chk(vsync == 1'b1, "R6 vsync idle high", vsync, 1);

    c1 = cyc;
    push_raster(c1 + 1, 240, 5, 3, 2, 1, 1, 4, 2, 2, 1, 1);
    wr(3'd5, EN | (32'd4 << 8));
    wait_cyc(c1 + 245);
    chk(q.size() == 0, "R9 all samples compared", q.size(), 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule